// File: doc/BRIEF.md
# Centralized Layer Allocator for an Inverse-Multiplexed Cell Switch

This block sits in front of a switch fabric built from K identical lower-rate layer switches running side by side. Every arriving cell must be sent into exactly one layer. Each external input link can start a new cell into a given layer only once per window of HOLD = ceil(K/S) time slots, where S is the internal speedup. Each layer can likewise start delivering to a given external output only once per HOLD departure slots. The allocator keeps both sets of restrictions. For each arrival it picks a layer that is free on the source side and also free on the output side for every destination in the cell's mask, in the cell's departure slot. It also gives each accepted cell a global sequence stamp, and the output recombiner releases cells in stamp order.

Arrivals are presented one per clock, with the lower-indexed input first within a time slot. A `slot_tick` pulse marks the first cycle of each new time slot. Input-side availability uses one countdown per (input, layer). Output-side availability keeps, per (output, layer), the last departure slot booked there. Departure slots toward a given output are assumed never to decrease and to stay within half the slot counter's range. When no layer qualifies, or the destination mask is unusable, the allocator reports an error for that cell and leaves all of its state unchanged.

Top module: `cell_layer_alloc`

## Requirements
- R1: Each cycle with `arr_valid` high produces exactly one result with `res_valid` high on the following cycle. A cycle with `arr_valid` low produces `res_valid` low on the following cycle.
- R2: Once input i is granted layer l in time slot s, layer l is not granted to input i again during slots s through s+HOLD-1. It may be granted again from slot s+HOLD onward. An arrival in a `slot_tick` cycle belongs to the new slot. With the default parameters, HOLD = 2.
- R3: Once layer l is booked to deliver to output j at departure slot d, it is not booked to output j for any departure slot d' with (d' - d) mod 2^SLOT_W < HOLD.
- R4: When several layers qualify, the one with the lowest index is granted.
- R5: For a cell whose mask has several bits set (mask bit j = output j), the granted layer meets the output condition of R3 for every destination in the mask, and the booking is recorded for every one of them.
- R6: Accepted cells receive stamps 0, 1, 2, ... in order of acceptance after reset. A rejected cell consumes no stamp.
- R7: If no layer qualifies, the result has `res_err` = 1 and `res_layer` = 0, and no availability state changes.
- R8: A cell with an all-zero mask, or with more than FANOUT_MAX mask bits set (default 2), is rejected with `res_err` = 1.
- R9: An input that has started no cell for HOLD slots has all K layers available again.
- R10: Reset (synchronous, active low) makes every layer available to every input and output, restarts stamps at 0 and clears `res_valid` and `res_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_tick | input | 1 | High in the first cycle of each new time slot |
| arr_valid | input | 1 | An arrival is presented this cycle |
| arr_src | input | $clog2(N_IN) | Index of the input the cell arrived on |
| arr_dst | input | N_OUT | Destination mask, bit j = output j |
| arr_dep_slot | input | SLOT_W | Departure slot of the cell |
| res_valid | output | 1 | A result is present |
| res_err | output | 1 | The cell could not be placed |
| res_layer | output | $clog2(K) | Granted layer (0 on error) |
| res_stamp | output | TS_W | Global stamp of the last accepted cell |

## Verification
The checker confirms on every cycle that results follow arrivals one for one. It also confirms that empty and over-wide masks are rejected, that a rejected cell reports layer 0, that accepted stamps step by exactly one, and that one input never receives the same layer twice in a row within a single slot. The exact layer choice takes scenarios from the bench. These cover lowest-index priority, the multi-slot window that closes and then reopens, and output bookings that collide in the same departure slot or in an adjacent one. The bench also covers a multicast cell that must avoid layers held by both of its outputs, and the recovery of full availability after reset.

// File: rtl/cla_pkg.sv
// Shared helpers for the cell layer allocator.
// Assumes: arguments are positive integers.
package cla_pkg;
    // Integer division rounding upward, used for the reuse window length.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
endpackage

// File: rtl/cla_in_avail.sv
// Input-side availability: one countdown per (input, layer).
// A counter is loaded with HOLD when its layer is granted to the input and
// counts down once per slot tick. The layer is free at zero, and also at one
// during a tick cycle, because that cycle already opens the next slot.
// Assumes: sel_src < N_IN.
module cla_in_avail #(
    parameter int N_IN  = 4,
    parameter int K     = 4,
    parameter int HOLD  = 2,
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_tick,
    input  logic [SRC_W-1:0] sel_src,
    input  logic             commit,
    input  logic [K-1:0]     commit_oh,
    output logic [K-1:0]     avail
);
    localparam int CNT_W = $clog2(HOLD + 1);

    logic [CNT_W-1:0] cnt [N_IN][K];

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        for (genvar l = 0; l < K; l++) begin : g_lyr
            // Reload on grant, otherwise count down at each slot boundary.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt[i][l] <= '0;
                else if (commit && (sel_src == SRC_W'(i)) && commit_oh[l])
                    cnt[i][l] <= CNT_W'(HOLD);
                else if (slot_tick && (cnt[i][l] != '0))
                    cnt[i][l] <= cnt[i][l] - 1'b1;
            end
        end
    end

    // Availability of each layer for the selected input in the current slot.
    always_comb begin
        for (int l = 0; l < K; l++)
            avail[l] = (cnt[sel_src][l] == '0) ||
                       (slot_tick && (cnt[sel_src][l] == CNT_W'(1)));
    end
endmodule

// File: rtl/cla_out_avail.sv
// Output-side availability: last booked departure slot per (output, layer).
// A layer is free to an output for departure slot d when it was never booked
// there, or when d is at least HOLD slots after the last booking (modular).
// Assumes: departure slots per output never decrease and stay within half
// the slot counter range of each other.
module cla_out_avail #(
    parameter int N_OUT  = 4,
    parameter int K      = 4,
    parameter int HOLD   = 2,
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_OUT-1:0]  dst,
    input  logic [SLOT_W-1:0] dep_slot,
    input  logic              commit,
    input  logic [K-1:0]      commit_oh,
    output logic [K-1:0]      avail
);
    logic [SLOT_W-1:0] last [N_OUT][K];
    logic              used [N_OUT][K];
    logic [K-1:0]      ok_row [N_OUT];

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        for (genvar l = 0; l < K; l++) begin : g_lyr
            logic [SLOT_W-1:0] gap;
            assign gap = dep_slot - last[j][l];
            assign ok_row[j][l] = !used[j][l] || (gap >= SLOT_W'(HOLD));

            // Record the booking for every destination of a granted cell.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    used[j][l] <= 1'b0;
                    last[j][l] <= '0;
                end else if (commit && dst[j] && commit_oh[l]) begin
                    used[j][l] <= 1'b1;
                    last[j][l] <= dep_slot;
                end
            end
        end
    end

    // A layer qualifies only if every addressed output accepts it.
    always_comb begin
        avail = '1;
        for (int j = 0; j < N_OUT; j++)
            if (dst[j])
                avail = avail & ok_row[j];
    end
endmodule

// File: rtl/cla_pick.sv
// Lowest-index selection among qualifying layers.
// Assumes: nothing beyond K >= 1.
module cla_pick #(
    parameter int K     = 4,
    parameter int LYR_W = 2
) (
    input  logic [K-1:0]     req,
    output logic             found,
    output logic [LYR_W-1:0] idx,
    output logic [K-1:0]     onehot
);
    // Scan from the top so the lowest set bit is the one that remains.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int l = K - 1; l >= 0; l--) begin
            if (req[l]) begin
                found = 1'b1;
                idx   = LYR_W'(l);
            end
        end
        onehot = found ? (K'(1) << idx) : '0;
    end
endmodule

// File: rtl/cell_layer_alloc.sv
// Centralized layer allocator for an inverse-multiplexed cell switch.
// Takes one arrival per clock and grants the lowest layer free both at the
// source input and at every destination output for the departure slot. It
// stamps accepted cells in sequence. The result is registered and appears
// one cycle after the arrival.
// Assumes: arrivals of one slot are presented in input-index order, and
// slot_tick is high in the first cycle of each slot.
module cell_layer_alloc
    import cla_pkg::*;
#(
    parameter int N_IN       = 4,
    parameter int N_OUT      = 4,
    parameter int K          = 4,
    parameter int SPEEDUP    = 2,
    parameter int FANOUT_MAX = 2,
    parameter int SLOT_W     = 8,
    parameter int TS_W       = 16,
    localparam int SRC_W     = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int LYR_W     = (K > 1) ? $clog2(K) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_tick,
    input  logic              arr_valid,
    input  logic [SRC_W-1:0]  arr_src,
    input  logic [N_OUT-1:0]  arr_dst,
    input  logic [SLOT_W-1:0] arr_dep_slot,
    output logic              res_valid,
    output logic              res_err,
    output logic [LYR_W-1:0]  res_layer,
    output logic [TS_W-1:0]   res_stamp
);
    localparam int HOLD = ceil_div(K, SPEEDUP);

    logic [K-1:0]     in_ok;
    logic [K-1:0]     out_ok;
    logic             found;
    logic [LYR_W-1:0] pick_idx;
    logic [K-1:0]     pick_oh;
    logic             mask_ok;
    logic             commit;
    logic [TS_W-1:0]  next_stamp;

    cla_in_avail #(.N_IN(N_IN), .K(K), .HOLD(HOLD), .SRC_W(SRC_W)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_tick (slot_tick),
        .sel_src   (arr_src),
        .commit    (commit),
        .commit_oh (pick_oh),
        .avail     (in_ok)
    );

    cla_out_avail #(.N_OUT(N_OUT), .K(K), .HOLD(HOLD), .SLOT_W(SLOT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .dst       (arr_dst),
        .dep_slot  (arr_dep_slot),
        .commit    (commit),
        .commit_oh (pick_oh),
        .avail     (out_ok)
    );

    cla_pick #(.K(K), .LYR_W(LYR_W)) u_pick (
        .req    (in_ok & out_ok),
        .found  (found),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    // Mask must address at least one output and no more than the fanout limit.
    always_comb begin
        mask_ok = (arr_dst != '0) && ($countones(arr_dst) <= FANOUT_MAX);
        commit  = arr_valid && mask_ok && found;
    end

    // Register the result and advance the stamp on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_err    <= 1'b0;
            res_layer  <= '0;
            res_stamp  <= '0;
            next_stamp <= '0;
        end else begin
            res_valid <= arr_valid;
            res_err   <= arr_valid && !commit;
            res_layer <= commit ? pick_idx : '0;
            if (commit) begin
                res_stamp  <= next_stamp;
                next_stamp <= next_stamp + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cell_layer_alloc_chk.sv
// Protocol and ordering checks for cell_layer_alloc, attached by bind.
// Assumes: the parameters match the bound instance.
module cell_layer_alloc_chk #(
    parameter int N_IN       = 4,
    parameter int N_OUT      = 4,
    parameter int K          = 4,
    parameter int FANOUT_MAX = 2,
    parameter int SLOT_W     = 8,
    parameter int TS_W       = 16,
    parameter int SRC_W      = 2,
    parameter int LYR_W      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_tick,
    input logic              arr_valid,
    input logic [SRC_W-1:0]  arr_src,
    input logic [N_OUT-1:0]  arr_dst,
    input logic [SLOT_W-1:0] arr_dep_slot,
    input logic              res_valid,
    input logic              res_err,
    input logic [LYR_W-1:0]  res_layer,
    input logic [TS_W-1:0]   res_stamp
);
    logic            seen_ok;
    logic [TS_W-1:0] last_ok;

    // Remember the stamp of the most recent accepted cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_ok <= 1'b0;
            last_ok <= '0;
        end else if (res_valid && !res_err) begin
            seen_ok <= 1'b1;
            last_ok <= res_stamp;
        end
    end

    a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid |=> res_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_valid |=> !res_valid);

    a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && (arr_dst == '0)) |=> res_err);

    a_r8_fanout_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && ($countones(arr_dst) > FANOUT_MAX)) |=> res_err);

    a_r7_err_layer_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err) |-> (res_layer == '0));

    a_r6_stamp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_err && seen_ok) |-> (res_stamp == last_ok + 1'b1));

    a_r2_same_slot_reuse: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_err && $past(res_valid && !res_err) &&
         ($past(arr_src, 1) == $past(arr_src, 2)) && !$past(slot_tick, 1))
        |-> (res_layer != $past(res_layer)));
endmodule

bind cell_layer_alloc cell_layer_alloc_chk #(
    .N_IN(N_IN), .N_OUT(N_OUT), .K(K), .FANOUT_MAX(FANOUT_MAX),
    .SLOT_W(SLOT_W), .TS_W(TS_W), .SRC_W(SRC_W), .LYR_W(LYR_W)
) u_chk (.*);

// File: tb/tb_cell_layer_alloc.sv
// Bench for cell_layer_alloc: a table of arrivals with expected results,
// then directed tests for idle cycles and reset.
module tb_cell_layer_alloc;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       slot_tick;
    logic       arr_valid;
    logic [1:0] arr_src;
    logic [3:0] arr_dst;
    logic [7:0] arr_dep_slot;
    logic       res_valid;
    logic       res_err;
    logic [1:0] res_layer;
    logic [15:0] res_stamp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cell_layer_alloc dut (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
        .arr_valid(arr_valid), .arr_src(arr_src), .arr_dst(arr_dst),
        .arr_dep_slot(arr_dep_slot), .res_valid(res_valid), .res_err(res_err),
        .res_layer(res_layer), .res_stamp(res_stamp)
    );

    typedef struct packed {
        logic        tick;
        logic [1:0]  src;
        logic [3:0]  dst;
        logic [7:0]  dep;
        logic        err;
        logic [1:0]  lyr;
        logic [15:0] stamp;
        logic [7:0]  req;
    } vec_t;

    // K=4, speedup 2: HOLD = 2 slots; fanout limit 2.
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 4'b0001, 8'd10, 1'b0, 2'd0, 16'd0,  8'd4},  // R4 all free
        '{1'b0, 2'd0, 4'b0010, 8'd10, 1'b0, 2'd1, 16'd1,  8'd2},  // R2 in0 L0 busy
        '{1'b0, 2'd1, 4'b0001, 8'd10, 1'b0, 2'd1, 16'd2,  8'd3},  // R3 out0 L0 booked
        '{1'b0, 2'd2, 4'b0011, 8'd10, 1'b0, 2'd2, 16'd3,  8'd5},  // R5 multicast
        '{1'b0, 2'd3, 4'b0001, 8'd10, 1'b0, 2'd3, 16'd4,  8'd4},  // R4 last free
        '{1'b0, 2'd3, 4'b0001, 8'd10, 1'b1, 2'd0, 16'd0,  8'd7},  // R7 none left
        '{1'b1, 2'd0, 4'b0001, 8'd11, 1'b1, 2'd0, 16'd0,  8'd3},  // R3 adjacent slot
        '{1'b1, 2'd0, 4'b0001, 8'd12, 1'b0, 2'd0, 16'd5,  8'd2},  // R2 window reopens
        '{1'b0, 2'd0, 4'b0100, 8'd12, 1'b0, 2'd1, 16'd6,  8'd2},  // R2
        '{1'b0, 2'd0, 4'b1000, 8'd12, 1'b0, 2'd2, 16'd7,  8'd2},  // R2
        '{1'b0, 2'd0, 4'b1000, 8'd12, 1'b0, 2'd3, 16'd8,  8'd3},  // R3 out3 L2 booked
        '{1'b0, 2'd0, 4'b0010, 8'd12, 1'b1, 2'd0, 16'd0,  8'd7},  // R7 input exhausted
        '{1'b0, 2'd1, 4'b0111, 8'd12, 1'b1, 2'd0, 16'd0,  8'd8},  // R8 fanout 3
        '{1'b0, 2'd1, 4'b0000, 8'd12, 1'b1, 2'd0, 16'd0,  8'd8},  // R8 empty mask
        '{1'b1, 2'd0, 4'b0010, 8'd13, 1'b1, 2'd0, 16'd0,  8'd2},  // R2 window second slot
        '{1'b1, 2'd0, 4'b0010, 8'd14, 1'b0, 2'd0, 16'd9,  8'd9},  // R9 full set again
        '{1'b0, 2'd1, 4'b0010, 8'd14, 1'b0, 2'd1, 16'd10, 8'd3},  // R3 same dep slot
        '{1'b0, 2'd3, 4'b0100, 8'd15, 1'b0, 2'd0, 16'd11, 8'd9}   // R9 idle input
    };

    task automatic report(input bit ok, input string req, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic drive(input bit v, input bit t, input logic [1:0] s,
                         input logic [3:0] d, input logic [7:0] dp);
        arr_valid    = v;
        slot_tick    = t;
        arr_src      = s;
        arr_dst      = d;
        arr_dep_slot = dp;
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        arr_valid = 1'b0; slot_tick = 1'b0; arr_src = '0; arr_dst = '0; arr_dep_slot = '0;
        repeat (3) @(negedge clk);
        // R10: outputs idle out of reset.
        report(!res_valid && !res_err && res_stamp == 16'd0, "R10",
               $sformatf("reset outputs actual v=%0b e=%0b s=%0d expected 0 0 0",
                         res_valid, res_err, res_stamp));
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i].tick, VEC[i].src, VEC[i].dst, VEC[i].dep);
            report(res_valid && (res_err == VEC[i].err) &&
                   (res_layer == VEC[i].lyr) &&
                   (VEC[i].err || res_stamp == VEC[i].stamp),
                   $sformatf("R%0d", VEC[i].req),
                   $sformatf("vec %0d actual v=%0b e=%0b l=%0d s=%0d expected v=1 e=%0b l=%0d s=%0d",
                             i, res_valid, res_err, res_layer, res_stamp,
                             VEC[i].err, VEC[i].lyr, VEC[i].stamp));
        end

        // R1: idle arrival cycle gives no result.
        drive(1'b0, 1'b0, 2'd0, 4'b0001, 8'd15);
        report(!res_valid && !res_err, "R1",
               $sformatf("idle actual v=%0b e=%0b expected 0 0", res_valid, res_err));

        // R1: back-to-back arrivals after an idle cycle each get a result.
        drive(1'b1, 1'b0, 2'd2, 4'b1000, 8'd15);
        report(res_valid && !res_err && res_layer == 2'd0 && res_stamp == 16'd12, "R1",
               $sformatf("post idle actual v=%0b l=%0d s=%0d expected 1 0 12",
                         res_valid, res_layer, res_stamp));

        // R10: reset clears all bookings and restarts stamps.
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 2'd0, 4'b0000, 8'd0);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 2'd0, 4'b0001, 8'd15);
        report(res_valid && !res_err && res_layer == 2'd0 && res_stamp == 16'd0, "R10",
               $sformatf("after reset actual e=%0b l=%0d s=%0d expected 0 0 0",
                         res_err, res_layer, res_stamp));
        drive(1'b1, 1'b0, 2'd1, 4'b0010, 8'd15);
        report(res_valid && !res_err && res_layer == 2'd0 && res_stamp == 16'd1, "R6",
               $sformatf("second stamp actual e=%0b l=%0d s=%0d expected 0 0 1",
                         res_err, res_layer, res_stamp));
        drive(1'b0, 1'b0, 2'd0, 4'b0000, 8'd0);
        finish_run();
    end
endmodule